// File: doc/BRIEF.md
# Aligned Write Buffer with Target Address and Transfer Status

This block is the staging buffer that sits between the command decoder of a serial memory slave and its non-volatile array. A write opens with a start pulse that carries a two-byte target address. A stream of single data bits follows, and an end pulse closes the write. The buffer only works in whole aligned blocks. The low bits of the captured target address are cleared, so every write fills the block from offset zero, and a write that runs past the block wraps back to its first byte.

When a write closes, the block works out whether the number of bits received was a whole number of bytes. It records the answer in a read-only status byte. The same status byte also carries a copy-accepted flag. The copy engine outside the block sets this flag with a completion pulse once the buffered data has been committed, and the next write clears it. A power-loss input marks the buffer contents as untrustworthy until a later write closes cleanly.

The decoder reads back the captured address, the status byte and any buffer byte through plain combinational outputs. It uses them to return them to the bus master, and the copy step uses them to find the data.

Top module: `wbuf_scratchpad`

## Requirements
- R1: After reset, both target-address outputs read 0x00, every buffer byte reads 0x00, and the status byte reads 0x7F (partial flag set, copy-accepted flag clear).
- R2: One cycle after a write start, the low target-address output equals the start address low byte with bits 2..0 cleared, and the high output equals the start address high byte. Neither changes at any other time.
- R3: Status bits 6, 4, 3 and 2..0 always read 1, so the status byte is 0x5F with both flags clear; bit 5 is the partial flag and bit 7 the copy-accepted flag.
- R4: Data bits are taken least significant bit first. The k-th completed byte of a write (k from 0) lands at buffer index k mod 8 and can be read the cycle after its eighth bit.
- R5: Bits of a trailing incomplete byte are dropped and leave every buffer byte unchanged.
- R6: When a write closes, the partial flag becomes 1 if the number of bits received is not a multiple of 8, and becomes 0 otherwise (zero bits included).
- R7: A power-loss pulse sets the partial flag, clears the copy-accepted flag and abandons any open write. The partial flag stays set until a write closes with a whole number of bytes.
- R8: A write start clears the copy-accepted flag.
- R9: A copy-done pulse sets the copy-accepted flag only when the partial flag is clear and no write is open; otherwise it has no effect.
- R10: A write start while a write is already open restarts the block: bit count and byte index return to zero.
- R11: Data bits and end pulses that arrive while no write is open are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_loss | input | 1 | Power-loss pulse, invalidates contents |
| wr_start | input | 1 | Opens a write and captures the address |
| addr_lo | input | 8 | Target address low byte |
| addr_hi | input | 8 | Target address high byte |
| bit_en | input | 1 | Qualifies one data bit |
| bit_d | input | 1 | Data bit value |
| wr_end | input | 1 | Closes the open write |
| copy_done | input | 1 | Completion pulse from the copy engine |
| rd_idx | input | 3 | Buffer byte select for read-back |
| rd_data | output | 8 | Selected buffer byte |
| ta_lo | output | 8 | Captured aligned address low byte |
| ta_hi | output | 8 | Captured address high byte |
| es_byte | output | 8 | Ending offset and status byte |

## Verification
The assertions assume that the control pulses last one cycle each. They also assume that power loss takes priority over a write start, which in turn takes priority over an end pulse or a data bit in the same cycle. The bench drives only one control pulse per cycle, on the falling edge, so no ordering conflict ever arises. Bit counts are swept from zero to ten bytes so that wrap-around and every partial remainder are covered, and the low address byte is swept across all 256 values.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

  // Flags carried in the status byte
  typedef struct packed {
    logic aa;   // copy accepted
    logic pf;   // partial / invalid
  } wbuf_flags_t;

  // Clear the low zbits of an address byte
  function automatic logic [7:0] align_low(input logic [7:0] a, input int unsigned zbits);
    logic [7:0] m;
    m = 8'hFF << zbits;
    return a & m;
  endfunction

  // A write is partial when the bit count is not a multiple of eight
  function automatic logic is_partial(input logic [2:0] pos);
    return pos != 3'd0;
  endfunction

  // Status byte: flag positions are decoded by the bus side
  function automatic logic [7:0] pack_status(input wbuf_flags_t f, input logic [2:0] eoff);
    return {f.aa, 1'b1, f.pf, 1'b1, 1'b1, eoff};
  endfunction

endpackage

// File: rtl/wbuf_bitrx.sv
module wbuf_bitrx #(
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kill,
  input  logic             start,
  input  logic             stop,
  input  logic             bit_en,
  input  logic             bit_d,
  output logic             active,
  output logic [2:0]       bit_pos,
  output logic [IDX_W-1:0] byte_idx,
  output logic             byte_done,
  output logic [7:0]       byte_val,
  output logic             stop_eff
);

  localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);

  logic [7:0] sh_q;
  logic       take_bit;

  // Priority: kill > start > stop > data bit
  assign take_bit  = bit_en && active && !kill && !start && !stop;
  assign stop_eff  = stop && active && !kill && !start;
  assign byte_done = take_bit && (bit_pos == 3'd7);
  assign byte_val  = {bit_d, sh_q[7:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      bit_pos  <= 3'd0;
      byte_idx <= '0;
      sh_q     <= 8'h00;
    end else if (kill) begin
      active   <= 1'b0;
      bit_pos  <= 3'd0;
      byte_idx <= '0;
    end else if (start) begin
      active   <= 1'b1;
      bit_pos  <= 3'd0;
      byte_idx <= '0;
      sh_q     <= 8'h00;
    end else if (stop_eff) begin
      active   <= 1'b0;
    end else if (take_bit) begin
      sh_q    <= byte_val;
      bit_pos <= bit_pos + 3'd1;
      if (byte_done) byte_idx <= byte_idx + IDX_ONE;
    end
  end

  // R4
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> byte_idx == $past(byte_idx) + IDX_ONE);

  // R10
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !kill) |=> (active && bit_pos == 3'd0 && byte_idx == '0));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !start && !kill) |=> (!active && $stable(bit_pos)));

endmodule

// File: rtl/wbuf_store.sv
module wbuf_store #(
  parameter int unsigned BYTES = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [7:0]       wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [7:0]       rdata
);

  logic [7:0] mem_q [BYTES];

  generate
    for (genvar g = 0; g < BYTES; g++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            mem_q[g] <= 8'h00;
        else if (we && widx == IDX_W'(g))      mem_q[g] <= wdata;
      end
    end
  endgenerate

  assign rdata = mem_q[ridx];

  // R4
  byte_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem_q[$past(widx)] == $past(wdata));

endmodule

// File: rtl/wbuf_status.sv
module wbuf_status
  import wbuf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        kill,
  input  logic        start,
  input  logic        stop_eff,
  input  logic        active,
  input  logic [2:0]  bit_pos,
  input  logic        copy_done,
  output wbuf_flags_t flags
);

  logic copy_ok;

  assign copy_ok = copy_done && !flags.pf && !active && !start && !kill;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags.pf <= 1'b1;
      flags.aa <= 1'b0;
    end else if (kill) begin
      flags.pf <= 1'b1;
      flags.aa <= 1'b0;
    end else if (start) begin
      flags.aa <= 1'b0;
    end else if (stop_eff) begin
      flags.pf <= is_partial(bit_pos);
    end else if (copy_ok) begin
      flags.aa <= 1'b1;
    end
  end

  // R8
  start_clears_aa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !flags.aa);

  // R7
  loss_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> (flags.pf && !flags.aa));

  // R6
  partial_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_eff && bit_pos != 3'd0) |=> flags.pf);

  // R9
  copy_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    copy_ok |=> flags.aa);

  // R9
  copy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_done && (flags.pf || active) && !start && !kill && !stop_eff) |=> $stable(flags.aa));

endmodule

// File: rtl/wbuf_scratchpad.sv
module wbuf_scratchpad
  import wbuf_pkg::*;
#(
  parameter int unsigned BLK_BYTES = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         pwr_loss,
  input  logic                         wr_start,
  input  logic [7:0]                   addr_lo,
  input  logic [7:0]                   addr_hi,
  input  logic                         bit_en,
  input  logic                         bit_d,
  input  logic                         wr_end,
  input  logic                         copy_done,
  input  logic [$clog2(BLK_BYTES)-1:0] rd_idx,
  output logic [7:0]                   rd_data,
  output logic [7:0]                   ta_lo,
  output logic [7:0]                   ta_hi,
  output logic [7:0]                   es_byte
);

  // BLK_BYTES: power of two, 2..8
  localparam int unsigned IDX_W = $clog2(BLK_BYTES);
  localparam logic [2:0]  EOFF  = 3'(BLK_BYTES - 1);

  logic             active;
  logic [2:0]       bit_pos;
  logic [IDX_W-1:0] byte_idx;
  logic             byte_done;
  logic [7:0]       byte_val;
  logic             stop_eff;
  wbuf_flags_t      flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ta_lo <= 8'h00;
      ta_hi <= 8'h00;
    end else if (wr_start && !pwr_loss) begin
      ta_lo <= align_low(addr_lo, IDX_W);
      ta_hi <= addr_hi;
    end
  end

  wbuf_bitrx #(.IDX_W(IDX_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .kill(pwr_loss), .start(wr_start), .stop(wr_end),
    .bit_en(bit_en), .bit_d(bit_d), .active(active), .bit_pos(bit_pos),
    .byte_idx(byte_idx), .byte_done(byte_done), .byte_val(byte_val), .stop_eff(stop_eff)
  );

  wbuf_store #(.BYTES(BLK_BYTES), .IDX_W(IDX_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(byte_done), .widx(byte_idx), .wdata(byte_val),
    .ridx(rd_idx), .rdata(rd_data)
  );

  wbuf_status u_st (
    .clk(clk), .rst_n(rst_n), .kill(pwr_loss), .start(wr_start), .stop_eff(stop_eff),
    .active(active), .bit_pos(bit_pos), .copy_done(copy_done), .flags(flags)
  );

  assign es_byte = pack_status(flags, EOFF);

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_start || pwr_loss) |=> $stable({ta_hi, ta_lo}));

endmodule

// File: tb/wbuf_scratchpad_test.sv
module wbuf_scratchpad_test;

  localparam int BB = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pwr_loss = 1'b0;
  logic          wr_start = 1'b0;
  logic [7:0]    addr_lo = 8'h00;
  logic [7:0]    addr_hi = 8'h00;
  logic          bit_en = 1'b0;
  logic          bit_d = 1'b0;
  logic          wr_end = 1'b0;
  logic          copy_done = 1'b0;
  logic [IW-1:0] rd_idx = '0;
  logic [7:0]    rd_data, ta_lo, ta_hi, es_byte;

  int nchk = 0;
  int nerr = 0;
  logic [7:0] model [BB];

  always #10 clk = ~clk;

  wbuf_scratchpad #(.BLK_BYTES(BB)) uut (
    .clk(clk), .rst_n(rst_n), .pwr_loss(pwr_loss), .wr_start(wr_start),
    .addr_lo(addr_lo), .addr_hi(addr_hi), .bit_en(bit_en), .bit_d(bit_d),
    .wr_end(wr_end), .copy_done(copy_done), .rd_idx(rd_idx), .rd_data(rd_data),
    .ta_lo(ta_lo), .ta_hi(ta_hi), .es_byte(es_byte)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask
  task automatic do_start(input logic [7:0] lo, input logic [7:0] hi);
    addr_lo = lo; addr_hi = hi; wr_start = 1'b1; step(); wr_start = 1'b0;
  endtask
  task automatic do_end();  wr_end = 1'b1;    step(); wr_end = 1'b0;    endtask
  task automatic do_copy(); copy_done = 1'b1; step(); copy_done = 1'b0; endtask
  task automatic do_loss(); pwr_loss = 1'b1;  step(); pwr_loss = 1'b0;  endtask

  // Expected status from the flag positions of R3
  function automatic logic [7:0] exp_es(input logic aa, input logic pf);
    return 8'h5F + (aa ? 8'h80 : 8'h00) + (pf ? 8'h20 : 8'h00);
  endfunction

  function automatic logic [7:0] pat(input int tag, input int k);
    return 8'((k * 29 + tag * 7 + 3) % 256);
  endfunction

  // Sends n bits LSB first; upd=1 updates the model for whole bytes
  task automatic send_bits(input int tag, input int n, input bit upd);
    for (int j = 0; j < n; j++) begin
      logic [7:0] v;
      v = pat(tag, j / 8);
      bit_en = 1'b1; bit_d = v[j % 8];
      step();
      bit_en = 1'b0;
      if (upd && (j % 8 == 7)) model[(j / 8) % BB] = v;
    end
  endtask

  task automatic check_mem(input string req);
    for (int i = 0; i < BB; i++) begin
      rd_idx = IW'(i); #1;
      chk(req, rd_data, model[i]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog act=timeout exp=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    for (int i = 0; i < BB; i++) model[i] = 8'h00;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    chk("R1 ta_lo", ta_lo, 8'h00);
    chk("R1 ta_hi", ta_hi, 8'h00);
    chk("R1 es", es_byte, 8'h7F);
    check_mem("R1 mem");

    // R2/R3/R6 address sweep with zero-bit writes
    for (int a = 0; a < 256; a++) begin
      do_start(8'(a), 8'(255 - a));
      chk("R2 ta_lo", ta_lo, 8'((a / 8) * 8));
      chk("R2 ta_hi", ta_hi, 8'(255 - a));
      do_end();
      chk("R3 es fixed bits", es_byte & 8'h5F, 8'h5F);
      chk("R6 zero bits", es_byte, 8'h5F);
    end
    check_mem("R5 mem untouched");

    // R4/R5/R6/R8/R9 bit-count sweep 0..80
    for (int n = 0; n <= 80; n++) begin
      do_start(8'(8'h40 + n), 8'(n));
      chk("R8 aa cleared", es_byte & 8'h80, 8'h00);
      send_bits(n, n, 1'b1);
      do_end();
      chk("R6 pf", es_byte, exp_es(1'b0, (n % 8) != 0));
      check_mem("R4 R5 mem");
      do_copy();
      chk("R9 copy", es_byte, exp_es((n % 8) == 0, (n % 8) != 0));
    end

    // R9 copy while a write is open
    do_start(8'h11, 8'h22);
    do_copy();
    chk("R9 open write", es_byte & 8'h80, 8'h00);
    send_bits(200, 8, 1'b1);
    do_end();
    chk("R9 after close", es_byte, 8'h5F);
    check_mem("R4 mem");

    // R11 stray bits and end pulses
    send_bits(201, 8, 1'b0);
    check_mem("R11 stray bits");
    do_start(8'h00, 8'h00);
    send_bits(202, 3, 1'b0);
    do_end();
    chk("R6 three bits", es_byte, 8'h7F);
    do_end();
    chk("R11 stray end", es_byte, 8'h7F);
    check_mem("R5 partial");

    // R7 power loss
    do_start(8'h08, 8'h01);
    send_bits(203, 64, 1'b1);
    do_end();
    do_copy();
    chk("R9 accepted", es_byte, 8'hDF);
    do_loss();
    chk("R7 loss", es_byte, 8'h7F);
    do_copy();
    chk("R7 copy refused", es_byte, 8'h7F);
    do_start(8'h10, 8'h02);
    send_bits(204, 5, 1'b0);
    do_end();
    chk("R7 partial keeps pf", es_byte, 8'h7F);
    do_start(8'h18, 8'h03);
    send_bits(205, 8, 1'b1);
    do_loss();
    send_bits(206, 8, 1'b0);
    do_end();
    chk("R7 loss mid write", es_byte, 8'h7F);
    check_mem("R7 mem");
    do_start(8'h20, 8'h04);
    send_bits(207, 16, 1'b1);
    do_end();
    chk("R7 cleared by whole write", es_byte, 8'h5F);
    check_mem("R4 mem");

    // R10 restart during an open write
    do_start(8'h28, 8'h05);
    send_bits(208, 8, 1'b1);
    send_bits(209, 5, 1'b0);
    do_start(8'h30, 8'h06);
    send_bits(210, 8, 1'b1);
    do_end();
    chk("R10 restart pf", es_byte, 8'h5F);
    chk("R10 restart ta", ta_lo, 8'h30);
    check_mem("R10 mem");

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule